// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit status word of a small processor core. Four arithmetic flags are held here: carry, half carry, zero and overflow. The block works them out from the ALU operands, the carry input, the result and the operation class of each instruction, then stores them. Two system flags are kept beside them. One is a watchdog-expired flag and the other is a sleep flag. Only watchdog, clear-watchdog, halt and power-on events move those two.

The ALU supplies its operands, its carry input and its result, together with an operation code and a per-flag update mask. The watchdog and the sequencer pulse the event strobes. A data-bus write port loads the four arithmetic flags. The two system flags cannot be written from the bus. When the ALU writes a flag in the same cycle as a bus write, the ALU value is kept. Subtraction is formed as a + ~b + cin, so carry and half carry read as "no borrow" after a subtract. The ALU datapath itself and the watchdog counter are outside this block.

Top module: `psw_status`

## Requirements
- R1: Status bits 7 and 6 always read 0.
- R2: Bit 5 (watchdog-expired) is set one cycle after `wdt_timeout`. It is cleared one cycle after `clr_wdt` or `halt`. When the set and a clear come in the same cycle, the set wins.
- R3: Bit 4 (sleep) is set one cycle after `halt` and cleared one cycle after `clr_wdt`. When both come in the same cycle, `halt` wins.
- R4: While `rst_n` is low, the whole status word reads 0x00.
- R5: For op code 0 (add), bit 0 is the carry out of a+b+cin and bit 1 is the carry out of bit 3.
- R6: For op code 1 (subtract), b is inverted. Bit 0 is 1 when a-b-(1-cin) causes no borrow, and bit 1 is 1 when the low nibble causes no borrow.
- R7: For add and subtract, bit 3 is the carry into bit 7 XOR the carry out of bit 7, which is signed overflow.
- R8: For add, subtract and op code 4 (logic), bit 2 is 1 exactly when `alu_res` is 0.
- R9: Op code 2 (rotate left through carry) loads a[7] into bit 0. Op code 3 (rotate right through carry) loads a[0] into bit 0. No other flag changes.
- R10: Op code 4 changes only bit 2. Op codes 5 to 7 change no flag.
- R11: A flag whose `flag_en` bit is 0 is left as it is by the ALU. The `flag_en` bits are [0]=carry, [1]=half carry, [2]=zero, [3]=overflow.
- R12: `wr_en` loads `wr_data[3:0]` into status bits 3..0 on the next edge. It never changes bits 5 and 4.
- R13: When the ALU updates a flag and `wr_en` is high in the same cycle, the ALU value is stored for that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| alu_valid | input | 1 | An ALU operation completes this cycle |
| alu_op | input | 3 | Operation class code |
| alu_a | input | DATA_W | First operand |
| alu_b | input | DATA_W | Second operand |
| alu_cin | input | 1 | Carry input (1 for a plain subtract) |
| alu_res | input | DATA_W | ALU result |
| flag_en | input | 4 | Per-flag update mask |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 4 | Bus value for bits 3..0 |
| wdt_timeout | input | 1 | Watchdog expired |
| clr_wdt | input | 1 | Clear-watchdog event |
| halt | input | 1 | Halt event |
| status | output | 8 | Status word |

## Verification
A large random run mixes all eight op codes, random update masks, bus writes and event strobes. A bench model written in signed and unsigned integer arithmetic predicts every result. That model tells borrow-style carries apart from add-style carries, and tells signed overflow apart from unsigned carry. Directed cases cover the edges: nibble and byte carries such as 0x0F+0x01 and 0xFF+0x01, the overflow pairs 0x7F+0x01 and 0x80+0x80, and borrows from 0x10-0x01 and 0x00-0x01. Further cases use zero and non-zero logic results, both rotate directions, masked updates, and bus writes that collide with ALU writes. Simultaneous set and clear strobes pin down the event priority of both system flags.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam logic [2:0] OP_ADD   = 3'd0;
  localparam logic [2:0] OP_SUB   = 3'd1;
  localparam logic [2:0] OP_RLC   = 3'd2;
  localparam logic [2:0] OP_RRC   = 3'd3;
  localparam logic [2:0] OP_LOGIC = 3'd4;

  localparam int NFLAG  = 4;
  localparam int IDX_C  = 0;
  localparam int IDX_AC = 1;
  localparam int IDX_Z  = 2;
  localparam int IDX_OV = 3;

  // flags touched by each op class, ordered {ov, z, ac, c}
  function automatic logic [NFLAG-1:0] touch_mask(logic [2:0] op);
    case (op)
      OP_ADD, OP_SUB: return 4'b1111;
      OP_RLC, OP_RRC: return 4'b0001;
      OP_LOGIC:       return 4'b0100;
      default:        return 4'b0000;
    endcase
  endfunction

  // one full-adder carry stage
  function automatic logic carry_stage(logic x, logic y, logic ci);
    return (x & y) | ((x ^ y) & ci);
  endfunction
endpackage

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
  import psw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic [DATA_W-1:0] res,
  output logic [NFLAG-1:0]  val,
  output logic [NFLAG-1:0]  touch
);
  localparam int NIB = 4;
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   chain;   // chain[k] = carry into bit k
  logic carry_out, carry_half, carry_msb_in, new_c, new_z, new_ov;

  assign b_eff    = (op == OP_SUB) ? ~b : b;
  assign chain[0] = cin;

  for (genvar k = 0; k < DATA_W; k++) begin : g_ripple
    assign chain[k+1] = carry_stage(a[k], b_eff[k], chain[k]);
  end

  assign carry_out    = chain[DATA_W];
  assign carry_half   = chain[NIB];
  assign carry_msb_in = chain[MSB];
  assign new_ov       = carry_msb_in ^ carry_out;
  assign new_z        = (res == '0);

  always_comb begin
    case (op)
      OP_RLC:  new_c = a[MSB];
      OP_RRC:  new_c = a[0];
      default: new_c = carry_out;
    endcase
  end

  assign val   = {new_ov, new_z, carry_half, new_c};
  assign touch = touch_mask(op);

  always_comb begin
    if (op == OP_RLC || op == OP_RRC)
      AST_ROT_TOUCH_C: assert (touch == 4'b0001); // R9
  end
endmodule

// File: rtl/psw_sys_flags.sv
module psw_sys_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_timeout,
  input  logic clr_wdt,
  input  logic halt,
  output logic to_q,
  output logic pd_q
);
  logic to_set, to_clr, pd_set, pd_clr;

  assign to_set = wdt_timeout;
  assign to_clr = clr_wdt | halt;
  assign pd_set = halt;
  assign pd_clr = clr_wdt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b0;
      pd_q <= 1'b0;
    end else begin
      if (to_set)      to_q <= 1'b1;
      else if (to_clr) to_q <= 1'b0;
      if (pd_set)      pd_q <= 1'b1;
      else if (pd_clr) pd_q <= 1'b0;
    end
  end

  AST_TO_SETS:   assert property (@(posedge clk) disable iff (!rst_n) wdt_timeout |=> to_q); // R2
  AST_TO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                   (clr_wdt || halt) && !wdt_timeout |=> !to_q); // R2
  AST_PD_SETS:   assert property (@(posedge clk) disable iff (!rst_n) halt |=> pd_q); // R3
  AST_PD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) clr_wdt && !halt |=> !pd_q); // R3
  AST_PD_HOLDS:  assert property (@(posedge clk) disable iff (!rst_n)
                   !clr_wdt && !halt |=> $stable(pd_q)); // R3
endmodule

// File: rtl/psw_status.sv
module psw_status
  import psw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_valid,
  input  logic [2:0]        alu_op,
  input  logic [DATA_W-1:0] alu_a,
  input  logic [DATA_W-1:0] alu_b,
  input  logic              alu_cin,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [3:0]        flag_en,
  input  logic              wr_en,
  input  logic [3:0]        wr_data,
  input  logic              wdt_timeout,
  input  logic              clr_wdt,
  input  logic              halt,
  output logic [7:0]        status
);
  logic [NFLAG-1:0] calc_val, calc_touch, alu_hit, ar_d, ar_q;
  logic             to_q, pd_q;

  psw_flag_calc #(.DATA_W(DATA_W)) u_calc (
    .op(alu_op), .a(alu_a), .b(alu_b), .cin(alu_cin), .res(alu_res),
    .val(calc_val), .touch(calc_touch)
  );

  psw_sys_flags u_sys (
    .clk(clk), .rst_n(rst_n), .wdt_timeout(wdt_timeout),
    .clr_wdt(clr_wdt), .halt(halt), .to_q(to_q), .pd_q(pd_q)
  );

  assign alu_hit = {NFLAG{alu_valid}} & flag_en & calc_touch;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign ar_d[i] = alu_hit[i] ? calc_val[i] : (wr_en ? wr_data[i] : ar_q[i]);

    AST_WR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !alu_hit[i] |=> ar_q[i] == $past(wr_data[i])); // R12
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !alu_hit[i] && !wr_en |=> $stable(ar_q[i])); // R11
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ar_q <= '0;
    else        ar_q <= ar_d;
  end

  assign status = {2'b00, to_q, pd_q, ar_q};

  AST_ZERO_FROM_RES: assert property (@(posedge clk) disable iff (!rst_n)
    alu_hit[IDX_Z] |=> status[IDX_Z] == ($past(alu_res) == '0)); // R8
  AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid && alu_op == OP_LOGIC && !wr_en |=> $stable(status[IDX_C])); // R10
  AST_ALU_OVER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    alu_hit[IDX_C] && wr_en && alu_op == OP_RLC |=> status[IDX_C] == $past(alu_a[DATA_W-1])); // R13
endmodule

// File: tb/sim_psw_status.sv
module sim_psw_status;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alu_valid = 1'b0;
  logic [2:0] alu_op = '0;
  logic [7:0] alu_a = '0, alu_b = '0, alu_res = '0;
  logic       alu_cin = 1'b0;
  logic [3:0] flag_en = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic       wdt_timeout = 1'b0, clr_wdt = 1'b0, halt = 1'b0;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_s = 8'h00;

  always #(CLK_PER/2) clk = ~clk;

  psw_status u0 (
    .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_op(alu_op),
    .alu_a(alu_a), .alu_b(alu_b), .alu_cin(alu_cin), .alu_res(alu_res),
    .flag_en(flag_en), .wr_en(wr_en), .wr_data(wr_data),
    .wdt_timeout(wdt_timeout), .clr_wdt(clr_wdt), .halt(halt), .status(status)
  );

  // integer-arithmetic reference: returns {ov, ac, c, result}
  function automatic logic [10:0] ref_arith(logic sub, logic [7:0] a, logic [7:0] b, logic ci);
    int ua = a, ub = b, sa = $signed(a), sb = $signed(b);
    int s, h, ss;
    logic c, ac, ov;
    if (!sub) begin
      s = ua + ub + ci; h = (ua % 16) + (ub % 16) + ci; ss = sa + sb + ci;
      c = (s > 255); ac = (h > 15);
    end else begin
      s = ua - ub - (1 - ci); h = (ua % 16) - (ub % 16) - (1 - ci); ss = sa - sb - (1 - ci);
      c = (s >= 0); ac = (h >= 0);
    end
    ov = (ss > 127) || (ss < -128);
    return {ov, ac, c, 8'(s & 255)};
  endfunction

  function automatic logic [7:0] model_next(logic [7:0] s, logic v, logic [2:0] op,
      logic [7:0] a, logic [7:0] b, logic ci, logic [7:0] r, logic [3:0] en,
      logic we, logic [3:0] wd, logic tmo, logic clr, logic hlt);
    logic [7:0] n = s;
    logic [10:0] ar;
    if (tmo) n[5] = 1'b1; else if (clr || hlt) n[5] = 1'b0;
    if (hlt) n[4] = 1'b1; else if (clr) n[4] = 1'b0;
    if (we) n[3:0] = wd;
    if (v) begin
      if (op <= 3'd1) begin
        ar = ref_arith(op[0], a, b, ci);
        if (en[0]) n[0] = ar[8];
        if (en[1]) n[1] = ar[9];
        if (en[2]) n[2] = (r == 8'h00);
        if (en[3]) n[3] = ar[10];
      end else if (op == 3'd2) begin
        if (en[0]) n[0] = a[7];
      end else if (op == 3'd3) begin
        if (en[0]) n[0] = a[0];
      end else if (op == 3'd4) begin
        if (en[2]) n[2] = (r == 8'h00);
      end
    end
    n[7:6] = 2'b00;
    return n;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: status got %h expected %h", tag, got, want);
    end
  endtask

  // drive one cycle at a falling edge, compare at the next falling edge
  task automatic cyc(string tag, logic v, logic [2:0] op, logic [7:0] a, logic [7:0] b,
      logic ci, logic [7:0] r, logic [3:0] en, logic we, logic [3:0] wd,
      logic tmo, logic clr, logic hlt);
    alu_valid = v; alu_op = op; alu_a = a; alu_b = b; alu_cin = ci; alu_res = r;
    flag_en = en; wr_en = we; wr_data = wd; wdt_timeout = tmo; clr_wdt = clr; halt = hlt;
    exp_s = model_next(exp_s, v, op, a, b, ci, r, en, we, wd, tmo, clr, hlt);
    @(posedge clk);
    @(negedge clk);
    check(tag, status, exp_s);
  endtask

  function automatic logic [7:0] res_of(logic sub, logic [7:0] a, logic [7:0] b, logic ci);
    logic [10:0] ar = ref_arith(sub, a, b, ci);
    return ar[7:0];
  endfunction

  initial begin
    #(CLK_PER * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd24680));
    repeat (2) @(negedge clk);
    check("R4 reset", status, 8'h00);
    rst_n = 1'b1;

    // R5 add carries
    cyc("R5 nibble carry", 1, 3'd0, 8'h0F, 8'h01, 0, res_of(0, 8'h0F, 8'h01, 0), 4'hF, 0, 0, 0, 0, 0);
    cyc("R5 byte carry",   1, 3'd0, 8'hFF, 8'h01, 0, res_of(0, 8'hFF, 8'h01, 0), 4'hF, 0, 0, 0, 0, 0);
    // R6 subtract no-borrow
    cyc("R6 nibble borrow", 1, 3'd1, 8'h10, 8'h01, 1, res_of(1, 8'h10, 8'h01, 1), 4'hF, 0, 0, 0, 0, 0);
    cyc("R6 byte borrow",   1, 3'd1, 8'h00, 8'h01, 1, res_of(1, 8'h00, 8'h01, 1), 4'hF, 0, 0, 0, 0, 0);
    // R7 overflow
    cyc("R7 pos overflow", 1, 3'd0, 8'h7F, 8'h01, 0, res_of(0, 8'h7F, 8'h01, 0), 4'hF, 0, 0, 0, 0, 0);
    cyc("R7 neg overflow", 1, 3'd0, 8'h80, 8'h80, 0, res_of(0, 8'h80, 8'h80, 0), 4'hF, 0, 0, 0, 0, 0);
    // R8 zero from logic result
    cyc("R8 logic zero",    1, 3'd4, 8'h55, 8'hAA, 0, 8'h00, 4'hF, 0, 0, 0, 0, 0);
    cyc("R8 logic nonzero", 1, 3'd4, 8'h55, 8'hAA, 0, 8'h01, 4'hF, 0, 0, 0, 0, 0);
    // R9 rotates
    cyc("R9 rotate left",  1, 3'd2, 8'h80, 8'h00, 0, 8'h00, 4'hF, 0, 0, 0, 0, 0);
    cyc("R9 rotate right", 1, 3'd3, 8'h02, 8'h00, 1, 8'h00, 4'hF, 0, 0, 0, 0, 0);
    // R10 logic touches only zero; codes 5-7 touch nothing
    cyc("R12 preset",       0, 3'd0, 8'h00, 8'h00, 0, 8'h00, 4'h0, 1, 4'hB, 0, 0, 0);
    cyc("R10 logic only Z", 1, 3'd4, 8'hFF, 8'hFF, 1, 8'h00, 4'hF, 0, 0, 0, 0, 0);
    cyc("R10 unused code",  1, 3'd6, 8'hFF, 8'h01, 0, 8'h00, 4'hF, 0, 0, 0, 0, 0);
    // R11 masked update
    cyc("R11 masked add", 1, 3'd0, 8'hFF, 8'hFF, 1, res_of(0, 8'hFF, 8'hFF, 1), 4'h0, 0, 0, 0, 0, 0);
    // R12 bus write leaves system flags
    cyc("R2 timeout sets",  0, 3'd0, 8'h00, 8'h00, 0, 8'h00, 4'h0, 0, 4'h0, 1, 0, 0);
    cyc("R12 bus write",    0, 3'd0, 8'h00, 8'h00, 0, 8'h00, 4'h0, 1, 4'h5, 0, 0, 0);
    // R13 collision: ALU wins per flag
    cyc("R13 alu over bus", 1, 3'd0, 8'h01, 8'h01, 0, 8'h02, 4'hF, 1, 4'hF, 0, 0, 0);
    cyc("R13 partial mask", 1, 3'd2, 8'h00, 8'h00, 0, 8'h00, 4'h1, 1, 4'hF, 0, 0, 0);
    // R2 / R3 event priority
    cyc("R3 halt sets",       0, 3'd0, 0, 0, 0, 0, 4'h0, 0, 4'h0, 0, 0, 1);
    cyc("R2 timeout+halt",    0, 3'd0, 0, 0, 0, 0, 4'h0, 0, 4'h0, 1, 0, 1);
    cyc("R3 clr+halt",        0, 3'd0, 0, 0, 0, 0, 4'h0, 0, 4'h0, 0, 1, 1);
    cyc("R2 R3 clr clears",   0, 3'd0, 0, 0, 0, 0, 4'h0, 0, 4'h0, 0, 1, 0);
    cyc("R2 timeout+clr",     0, 3'd0, 0, 0, 0, 0, 4'h0, 0, 4'h0, 1, 1, 0);
    cyc("R3 halt again",      0, 3'd0, 0, 0, 0, 0, 4'h0, 0, 4'h0, 0, 0, 1);
    checks++;
    if (status[7:6] !== 2'b00) begin
      errors++;
      $display("FAIL R1: upper bits got %b expected 00", status[7:6]);
    end

    // random mix, R5/R6/R7/R8 arithmetic against the integer model
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] op = 3'($urandom % 8);
      logic [7:0] a = 8'($urandom), b = 8'($urandom);
      logic ci = 1'($urandom);
      logic [7:0] r;
      if (op <= 3'd1) r = res_of(op[0], a, b, ci);
      else r = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
      cyc("R5/R6/R7/R8 random", 1'($urandom % 4 != 0), op, a, b, ci, r, 4'($urandom),
          1'($urandom % 3 == 0), 4'($urandom), 1'($urandom % 8 == 0),
          1'($urandom % 8 == 0), 1'($urandom % 8 == 0));
    end

    rst_n = 1'b0;
    #1;
    check("R4 reset again", status, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule